// File: doc/BRIEF.md
# Load fault monitor for four low-side switches

This block supervises four low-side output stages. For every channel it receives four comparator flags from the analog side: overcurrent (output shorted to the supply), open load, output shorted to ground, and overtemperature. Each flag has to stay asserted for its own filter window before it counts as a fault. The windows are measured in ticks of an internal oscillator, which is derived from the system clock by a divider. A flag is only counted while the channel is in the state where that flag means something. When a window expires, a bit is set in a sticky 16-bit failure register.

An overcurrent or overtemperature fault also forces the channel's gate enable low. The channel stays off until its command is released and asserted again. The failure register, the shutdown latches and all filters are cleared while the active-low reset input is low or the undervoltage flag is high. The gate enables go to the output stages and the failure bits go to the diagnostic readout logic.

Top module: `load_fault_monitor`

## Requirements
- R1: Channel commands are active low. With no fault latched and no clear active, `gate_en[i]` is 1 one clock after `cmd_n[i]` is sampled 0, and 0 one clock after it is sampled 1.
- R2: An oscillator tick occurs once every `TICK_DIV` clocks, and every filter window is counted in these ticks. A flag held for at most `(W-1)*TICK_DIV - 1` clocks never latches a window of `W` ticks. A flag held for `(W+1)*TICK_DIV` clocks always latches it.
- R3: Overcurrent is counted only while the channel is commanded on and not already shut down. After `OC_TICKS` ticks it sets failure bit `4*i+0` and drives `gate_en[i]` low on the next clock. If the flag drops before the window completes, the count restarts from zero.
- R4: Open load is counted only while the channel is commanded off. After `OL_TICKS` ticks it sets failure bit `4*i+1` and has no effect on the gate.
- R5: Short to ground is counted only while the channel is commanded off. After `SG_TICKS` ticks it sets failure bit `4*i+2`. A shorter pulse sets nothing.
- R6: Overtemperature is counted in any command state. After `OT_TICKS` ticks it sets failure bit `4*i+3` and shuts the channel's gate off.
- R7: A shut-down channel stays off while its command remains asserted, even after the flag clears. Releasing the command (`cmd_n[i]`=1) and asserting it again re-enables the gate.
- R8: Any change of a channel's command restarts all of that channel's filter counts, so a flag interval split by a command change does not add up across it.
- R9: A set failure bit stays set until a clear.
- R10: While `nres_n` is 0 or `uv_rst` is 1, all failure bits read 0 and all gate enables read 0 within two clocks. Once the clear is released, commanded channels switch on again.
- R11: Faults on one channel set only that channel's bits and affect only that channel's gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| nres_n | input | 1 | Active-low clear of failure register and shutdown latches |
| uv_rst | input | 1 | Undervoltage clear, active high |
| cmd_n | input | NCH | Active-low channel on commands |
| oc_flag | input | NCH | Overcurrent comparator flags |
| ol_flag | input | NCH | Open-load comparator flags |
| sg_flag | input | NCH | Short-to-ground comparator flags |
| ot_flag | input | NCH | Overtemperature flags |
| gate_en | output | NCH | Gate drive enables, 1 = stage on |
| fail_bits | output | 4*NCH | Sticky failures, bit 4*i+k with k = 0 OC, 1 OL, 2 SG, 3 OT |

## Verification
The assertions assume that the comparator flags and commands are already synchronous to `clk` and change at most once per clock, and that the clear inputs are level signals held for whole clocks. The stimulus changes inputs only on falling edges. It holds each flag for lengths chosen well clear of the ambiguous band of one tick around each window, so a result does not depend on the divider phase. The command-change test splits one overtemperature interval into parts that are each below the window but add up to more than it.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  localparam int FAULT_TYPES = 4;
  typedef enum logic [1:0] {
    FT_OC = 2'd0,
    FT_OL = 2'd1,
    FT_SG = 2'd2,
    FT_OT = 2'd3
  } fault_e;
endpackage

// File: rtl/lfm_tick_gen.sv
module lfm_tick_gen #(
  parameter int DIV = 154
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    if (cnt_q == LAST) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  generate
    if (DIV > 1) begin : g_chk
      // R2: ticks are isolated single-clock pulses
      a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
    end
  endgenerate
endmodule

// File: rtl/lfm_filter.sv
module lfm_filter #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic en_i,
  input  logic restart_i,
  output logic hit_o
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] FULL = CW'(WIN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || !en_i) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q != FULL)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign hit_o = en_i && !restart_i && (cnt_q == FULL);

  // R3: a completed window implies the flag was already qualified a clock earlier
  a_r3_hit_has_history: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(en_i));
endmodule

// File: rtl/lfm_channel.sv
module lfm_channel
  import lfm_pkg::*;
#(
  parameter int OC_TICKS = 4,
  parameter int OL_TICKS = 64,
  parameter int SG_TICKS = 60,
  parameter int OT_TICKS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic                   clr_i,
  input  logic                   cmd_n_i,
  input  logic                   oc_i,
  input  logic                   ol_i,
  input  logic                   sg_i,
  input  logic                   ot_i,
  output logic                   gate_o,
  output logic [FAULT_TYPES-1:0] fail_o
);
  localparam int WINS [FAULT_TYPES] = '{OC_TICKS, OL_TICKS, SG_TICKS, OT_TICKS};

  logic                   cmd_on_q, cmd_on_d;
  logic                   sd_q, sd_d;
  logic [FAULT_TYPES-1:0] fail_q, fail_d;
  logic [FAULT_TYPES-1:0] en, hit;
  logic                   restart;

  assign cmd_on_d = ~cmd_n_i;
  assign restart  = (cmd_on_d != cmd_on_q) || clr_i;

  always_comb begin
    en        = '0;
    en[FT_OC] = cmd_on_q & ~sd_q & oc_i;
    en[FT_OL] = ~cmd_on_q & ol_i;
    en[FT_SG] = ~cmd_on_q & sg_i;
    en[FT_OT] = ot_i;
  end

  generate
    for (genvar k = 0; k < FAULT_TYPES; k++) begin : g_flt
      lfm_filter #(.WIN(WINS[k])) u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .en_i      (en[k]),
        .restart_i (restart),
        .hit_o     (hit[k])
      );
    end
  endgenerate

  always_comb begin
    if (clr_i) begin
      fail_d = '0;
      sd_d   = 1'b0;
    end else begin
      fail_d = fail_q | hit;
      sd_d   = cmd_on_q & (sd_q | hit[FT_OC] | hit[FT_OT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_on_q <= 1'b0;
      sd_q     <= 1'b0;
      fail_q   <= '0;
    end else begin
      cmd_on_q <= cmd_on_d;
      sd_q     <= sd_d;
      fail_q   <= fail_d;
    end
  end

  assign gate_o = cmd_on_q & ~sd_q & ~clr_i;
  assign fail_o = fail_q;

  // R1: the gate is only on if the command was asserted one clock earlier
  a_r1_gate_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o |-> $past(!cmd_n_i));
  // R3: a completed overcurrent window turns the gate off next clock
  a_r3_oc_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[FT_OC] && !clr_i) |=> !gate_o);
  // R4: open-load bit only rises after a commanded-off clock
  a_r4_ol_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q[FT_OL]) |-> $past(!cmd_on_q));
  // R7: releasing the command frees the shutdown latch
  a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_on_q |=> !sd_q);
  // R9: no bit falls without a clear
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((fail_q & $past(fail_q)) == $past(fail_q)));
  // R10: a clear empties the failure bits
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (fail_q == '0));
endmodule

// File: rtl/load_fault_monitor.sv
module load_fault_monitor
  import lfm_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int TICK_DIV = 154,
  parameter int OC_TICKS = 4,
  parameter int OL_TICKS = 64,
  parameter int SG_TICKS = 60,
  parameter int OT_TICKS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       nres_n,
  input  logic                       uv_rst,
  input  logic [NCH-1:0]             cmd_n,
  input  logic [NCH-1:0]             oc_flag,
  input  logic [NCH-1:0]             ol_flag,
  input  logic [NCH-1:0]             sg_flag,
  input  logic [NCH-1:0]             ot_flag,
  output logic [NCH-1:0]             gate_en,
  output logic [FAULT_TYPES*NCH-1:0] fail_bits
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       clr_q, clr_d;
  logic       tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign clr_d = ~nres_n | uv_rst;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      clr_q <= 1'b0;
    end else begin
      clr_q <= clr_d;
    end
  end

  lfm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick_o (tick)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      lfm_channel #(
        .OC_TICKS (OC_TICKS),
        .OL_TICKS (OL_TICKS),
        .SG_TICKS (SG_TICKS),
        .OT_TICKS (OT_TICKS)
      ) u_ch (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .tick_i  (tick),
        .clr_i   (clr_q),
        .cmd_n_i (cmd_n[i]),
        .oc_i    (oc_flag[i]),
        .ol_i    (ol_flag[i]),
        .sg_i    (sg_flag[i]),
        .ot_i    (ot_flag[i]),
        .gate_o  (gate_en[i]),
        .fail_o  (fail_bits[FAULT_TYPES*i +: FAULT_TYPES])
      );
    end
  endgenerate

  // R10: an asserted clear input turns every gate off within two clocks
  a_r10_clear_gates_off: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr_d |=> (clr_q && (gate_en == '0)));
endmodule

// File: tb/load_fault_monitor_tb_top.sv
module load_fault_monitor_tb_top;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n, nres_n, uv_rst;
  logic [3:0]  cmd_n, oc_flag, ol_flag, sg_flag, ot_flag;
  logic [3:0]  gate_en;
  logic [15:0] fail_bits;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [15:0] fail;
    logic [3:0]  gate;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  load_fault_monitor #(
    .NCH(4), .TICK_DIV(D), .OC_TICKS(4), .OL_TICKS(64), .SG_TICKS(60), .OT_TICKS(8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .nres_n(nres_n), .uv_rst(uv_rst),
    .cmd_n(cmd_n), .oc_flag(oc_flag), .ol_flag(ol_flag), .sg_flag(sg_flag),
    .ot_flag(ot_flag), .gate_en(gate_en), .fail_bits(fail_bits)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(input logic [15:0] f, input logic [3:0] g, input string tag);
    exp_t it;
    it.fail = f;
    it.gate = g;
    it.tag  = tag;
    sb_q.push_back(it);
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  // monitor: pops expectations and compares against the ports
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      total++;
      if (fail_bits !== it.fail || gate_en !== it.gate) begin
        bad++;
        $display("FAIL %s: fail_bits=%h exp %h gate_en=%b exp %b",
                 it.tag, fail_bits, it.fail, gate_en, it.gate);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; nres_n = 1'b1; uv_rst = 1'b0;
    cmd_n = 4'hF; oc_flag = '0; ol_flag = '0; sg_flag = '0; ot_flag = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(5);
    expect_state(16'h0000, 4'b0000, "R10 reset state");

    cmd_n = 4'b1010; cyc(3);
    expect_state(16'h0000, 4'b0101, "R1 active-low commands");

    oc_flag[0] = 1'b1; cyc(3*D - 1); oc_flag[0] = 1'b0; cyc(5);
    expect_state(16'h0000, 4'b0101, "R2 R3 short overcurrent ignored");

    oc_flag[0] = 1'b1; cyc(5*D + 3);
    expect_state(16'h0001, 4'b0100, "R3 overcurrent latch and shutdown");
    oc_flag[0] = 1'b0; cyc(5);
    expect_state(16'h0001, 4'b0100, "R7 stays off after flag clears");

    oc_flag[1] = 1'b1; cyc(10*D); oc_flag[1] = 1'b0; cyc(3);
    expect_state(16'h0001, 4'b0100, "R3 overcurrent ignored when off");

    cmd_n[0] = 1'b1; cyc(3); cmd_n[0] = 1'b0; cyc(3);
    expect_state(16'h0001, 4'b0101, "R7 R9 command cycle re-enables");

    ol_flag[1] = 1'b1; ol_flag[0] = 1'b1; cyc(65*D); ol_flag = '0; cyc(3);
    expect_state(16'h0021, 4'b0101, "R4 open load only when off");

    sg_flag[3] = 1'b1; cyc(59*D - 1); sg_flag[3] = 1'b0; cyc(3);
    expect_state(16'h0021, 4'b0101, "R5 short ground pulse too short");
    sg_flag[3] = 1'b1; cyc(61*D); sg_flag[3] = 1'b0; cyc(3);
    expect_state(16'h4021, 4'b0101, "R5 short ground latched");

    ot_flag[2] = 1'b1; cyc(9*D); ot_flag[2] = 1'b0; cyc(3);
    expect_state(16'h4821, 4'b0001, "R6 R11 overtemperature shutdown");

    ot_flag[0] = 1'b1; cyc(40);
    cmd_n[0] = 1'b1; cyc(2); cmd_n[0] = 1'b0; cyc(40);
    ot_flag[0] = 1'b0; cyc(3);
    expect_state(16'h4821, 4'b0001, "R8 command change restarts filters");

    nres_n = 1'b0; cyc(3);
    expect_state(16'h0000, 4'b0000, "R10 reset input clears");
    nres_n = 1'b1; cyc(3);
    expect_state(16'h0000, 4'b0101, "R10 channels return after clear");

    ol_flag[3] = 1'b1; cyc(65*D); ol_flag[3] = 1'b0; cyc(3);
    expect_state(16'h2000, 4'b0101, "R11 R4 open load channel three");
    uv_rst = 1'b1; cyc(3);
    expect_state(16'h0000, 4'b0000, "R10 undervoltage clears");
    uv_rst = 1'b0; cyc(3);
    expect_state(16'h0000, 4'b0101, "R9 R1 state after undervoltage");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule